// File: doc/BRIEF.md
# Angle Hold Latch

The angle hold latch sits between a free-running angle counter and a host bus. While nothing is updating and the host is not reading, the latch is transparent and passes the counter word through. It holds the word at a stable value during a counter update, which the busy pulse marks, and during a host read, which the active-low inhibit marks. Busy has priority. An inhibit raised during a busy pulse keeps the latch closed after the pulse ends. A busy pulse that arrives while inhibit is held cannot change the held word.

Busy and inhibit are asynchronous and each passes through a synchronizer chain. The counter word goes through a delay line of `UPD_DLY` clock cycles before it reaches the latch. A lock caused by the rising edge of busy therefore takes effect before the new counter value arrives. The held word is presented on two byte lanes, upper and lower. Each lane has an active-low enable and a drive flag that controls the pad's output buffer.

The parameter `PROG_RES` selects the lane split. The programmable variant splits the word 8/8 at 16-bit resolution or 8/6 at 14-bit resolution, chosen by the `res16` pin. The fixed variant always splits a 14-bit word 6/8. All pins are plain level signals. The block has no handshake and no back-pressure, and a host reads by holding inhibit low and pulling the lane enables low.

Top module: `angle_hold_latch`

## Requirements
- R1: With the synchronized busy low and inhibit high, the latch is transparent. A counter value applied at `cnt_angle` appears on the lanes `UPD_DLY` clock edges after it is sampled.
- R2: While the synchronized busy is high, the lanes keep the word that was visible just before busy rose, whatever the inhibit level.
- R3: If inhibit goes low during a busy pulse, the lanes keep the pre-busy word after busy falls. They show the current counter only once inhibit returns high.
- R4: If busy rises while inhibit is already low, the held word does not change. New counter data shows only after busy is low and inhibit is high.
- R5: Inhibit is active low: 0 freezes the lanes and 1 lets them follow the counter again, within three clock edges of release.
- R6: Busy and inhibit each pass a two-flop synchronizer. `UPD_DLY` (at least 3) exceeds the synchronizer lag, so a counter change launched together with busy never reaches the lanes before the lock.
- R7: Programmable variant at 16-bit resolution (`res16`=1): the upper lane carries `cnt_angle[15:8]` and the lower lane carries `cnt_angle[7:0]`.
- R8: Programmable variant at 14-bit resolution (`res16`=0): the angle sits in `cnt_angle[13:0]`. The upper lane carries bits [13:6], and the lower lane carries bits [5:0] in lane bits [5:0] with lane bits [7:6] at 0.
- R9: Fixed variant (`PROG_RES`=0): the upper lane carries `cnt_angle[13:8]` in lane bits [5:0] with [7:6] at 0, and the lower lane carries `cnt_angle[7:0]`. `res16` has no effect.
- R10: A lane whose enable is 0 raises its drive flag and shows its data. A lane whose enable is 1 drops its drive flag and shows all zeros.
- R11: After reset the held word and the delay line are zero, and the latch is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busy_async | input | 1 | Counter update pulse, asynchronous, active high |
| inh_n_async | input | 1 | Host hold request, asynchronous, active low |
| cnt_angle | input | ANG_W | Counter angle word, synchronous to clk |
| res16 | input | 1 | Resolution select: 1 = 16-bit, 0 = 14-bit |
| hi_en_n | input | 1 | Upper lane enable, active low |
| lo_en_n | input | 1 | Lower lane enable, active low |
| hi_lane | output | ANG_W/2 | Upper lane data |
| hi_drv | output | 1 | Upper lane output-buffer enable |
| lo_lane | output | ANG_W/2 | Lower lane data |
| lo_drv | output | 1 | Lower lane output-buffer enable |

## Verification
A lock controller stuck open lets the new counter value reach the lanes `UPD_DLY` edges after a busy or inhibit edge, about five cycles at the default. A lock controller stuck closed makes the lanes fail to follow a new value within a few cycles after release. A wrong lane-map choice or bit slice corrupts specific bit positions as soon as the word settles, so a sweep of varied words under each resolution and both variants shows it at once. A delay line that is too short or too long shows up as a wrong value at the sampling cycle that follows a counter change.

// File: rtl/angle_hold_pkg.sv
package angle_hold_pkg;

  typedef enum logic [1:0] {
    ST_OPEN = 2'd0,
    ST_BUSY = 2'd1,
    ST_INH  = 2'd2
  } lock_state_e;

  localparam int unsigned NARROW_W = 14;

endpackage

// File: rtl/ahl_sync.sv
module ahl_sync #(
  parameter int unsigned          N      = 2,
  parameter int unsigned          STAGES = 2,
  parameter logic [N-1:0]         RST_V  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);

  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_V[b]}};
      else        chain_q <= {chain_q[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/ahl_delay_line.sv
module ahl_delay_line #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stage_q [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign dout = stage_q[DEPTH-1];

endmodule

// File: rtl/ahl_lock_ctrl.sv
module ahl_lock_ctrl
  import angle_hold_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        busy_s,
  input  logic        inh_n_s,
  output lock_state_e state_o,
  output logic        lock_o
);

  lock_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OPEN: begin
        if (busy_s)        state_d = ST_BUSY;
        else if (!inh_n_s) state_d = ST_INH;
      end
      ST_BUSY: begin
        if (!busy_s) state_d = inh_n_s ? ST_OPEN : ST_INH;
      end
      ST_INH: begin
        if (inh_n_s && !busy_s) state_d = ST_OPEN;
      end
      default: state_d = ST_OPEN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OPEN;
    else        state_q <= state_d;
  end

  // Closed while either request is live or the controller has not yet reopened.
  assign lock_o  = busy_s || !inh_n_s || (state_q != ST_OPEN);
  assign state_o = state_q;

  // R2: a busy cycle always leaves the controller in a locked state.
  a_r2_busy_locks: assert property (@(posedge clk) disable iff (!rst_n)
    busy_s |=> (state_q != ST_OPEN));

  // R3: inhibit raised during busy carries the lock past the end of the pulse.
  a_r3_inh_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BUSY && !busy_s && !inh_n_s) |=> (state_q == ST_INH));

  // R4: busy arriving under inhibit never reopens the latch.
  a_r4_inh_busy_stay: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_INH && busy_s) |=> (state_q == ST_INH));

endmodule

// File: rtl/ahl_lane_map.sv
module ahl_lane_map #(
  parameter int unsigned ANG_W    = 16,
  parameter bit          PROG_RES = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ANG_W-1:0]     angle_i,
  input  logic                 res16_i,
  output logic [ANG_W/2-1:0]   hi_o,
  output logic [ANG_W/2-1:0]   lo_o
);

  localparam int unsigned LANE_W = ANG_W / 2;
  localparam int unsigned NW     = angle_hold_pkg::NARROW_W;
  localparam int unsigned SHORT  = NW - LANE_W;

  if (PROG_RES) begin : g_prog
    always_comb begin
      if (res16_i) begin
        hi_o = angle_i[ANG_W-1 -: LANE_W];
        lo_o = angle_i[LANE_W-1:0];
      end else begin
        hi_o = angle_i[NW-1 -: LANE_W];
        lo_o = {{(LANE_W-SHORT){1'b0}}, angle_i[SHORT-1:0]};
      end
    end
  end else begin : g_fixed
    assign hi_o = {{(LANE_W-SHORT){1'b0}}, angle_i[NW-1:LANE_W]};
    assign lo_o = angle_i[LANE_W-1:0];

    // R9: changing the resolution pin alone leaves the fixed split untouched.
    a_r9_fixed_ignores_res: assert property (@(posedge clk) disable iff (!rst_n)
      (angle_i == $past(angle_i) && res16_i != $past(res16_i))
        |-> (hi_o == $past(hi_o) && lo_o == $past(lo_o)));
  end

endmodule

// File: rtl/angle_hold_latch.sv
module angle_hold_latch
  import angle_hold_pkg::*;
#(
  parameter int unsigned ANG_W       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned UPD_DLY     = 5,
  parameter bit          PROG_RES    = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               busy_async,
  input  logic               inh_n_async,
  input  logic [ANG_W-1:0]   cnt_angle,
  input  logic               res16,
  input  logic               hi_en_n,
  input  logic               lo_en_n,
  output logic [ANG_W/2-1:0] hi_lane,
  output logic               hi_drv,
  output logic [ANG_W/2-1:0] lo_lane,
  output logic               lo_drv
);

  localparam int unsigned LANE_W = ANG_W / 2;

  logic [1:0]       ctl_s;
  logic             busy_s, inh_n_s, lock;
  lock_state_e      lstate;
  logic [ANG_W-1:0] dly_word, held_q, view_word;
  logic [LANE_W-1:0] hi_word, lo_word;

  ahl_sync #(.N(2), .STAGES(SYNC_STAGES), .RST_V(2'b10)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({inh_n_async, busy_async}),
    .sync_o  (ctl_s)
  );
  assign busy_s  = ctl_s[0];
  assign inh_n_s = ctl_s[1];

  ahl_delay_line #(.W(ANG_W), .DEPTH(UPD_DLY)) u_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (cnt_angle),
    .dout  (dly_word)
  );

  ahl_lock_ctrl u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy_s  (busy_s),
    .inh_n_s (inh_n_s),
    .state_o (lstate),
    .lock_o  (lock)
  );

  // Hold register tracks the delayed word while open; the mux makes it a transparent latch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     held_q <= '0;
    else if (!lock) held_q <= dly_word;
  end
  assign view_word = lock ? held_q : dly_word;

  ahl_lane_map #(.ANG_W(ANG_W), .PROG_RES(PROG_RES)) u_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .angle_i (view_word),
    .res16_i (res16),
    .hi_o    (hi_word),
    .lo_o    (lo_word)
  );

  assign hi_drv  = !hi_en_n;
  assign lo_drv  = !lo_en_n;
  assign hi_lane = hi_drv ? hi_word : '0;
  assign lo_lane = lo_drv ? lo_word : '0;

  // R5: across consecutive locked cycles the presented word never moves.
  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && $past(lock)) |-> (view_word == $past(view_word)));

  // R3: in the inhibit-hold state the lanes are fed from the hold register.
  a_r3_inh_uses_held: assert property (@(posedge clk) disable iff (!rst_n)
    (lstate == ST_INH) |-> (view_word == held_q));

endmodule

// File: tb/test_angle_hold_latch.sv
module test_angle_hold_latch;

  localparam int CLK_PERIOD = 10;
  localparam int DLY        = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic busy = 1'b0;
  logic inh_n = 1'b1;
  logic [15:0] cnt = '0;
  logic res16 = 1'b1;
  logic hi_en_n = 1'b1;
  logic lo_en_n = 1'b1;

  logic [7:0] p_hi, p_lo, f_hi, f_lo;
  logic p_hd, p_ld, f_hd, f_ld;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  angle_hold_latch #(.UPD_DLY(DLY), .PROG_RES(1'b1)) i_angle_hold_latch (
    .clk(clk), .rst_n(rst_n), .busy_async(busy), .inh_n_async(inh_n),
    .cnt_angle(cnt), .res16(res16), .hi_en_n(hi_en_n), .lo_en_n(lo_en_n),
    .hi_lane(p_hi), .hi_drv(p_hd), .lo_lane(p_lo), .lo_drv(p_ld)
  );

  angle_hold_latch #(.UPD_DLY(DLY), .PROG_RES(1'b0)) i_angle_hold_latch_fix (
    .clk(clk), .rst_n(rst_n), .busy_async(busy), .inh_n_async(inh_n),
    .cnt_angle(cnt), .res16(res16), .hi_en_n(hi_en_n), .lo_en_n(lo_en_n),
    .hi_lane(f_hi), .hi_drv(f_hd), .lo_lane(f_lo), .lo_drv(f_ld)
  );

  function automatic logic [7:0] ex_hi(logic [15:0] v, bit prog, bit r16);
    if (!prog) return {2'b00, v[13:8]};
    if (r16)   return v[15:8];
    return v[13:6];
  endfunction

  function automatic logic [7:0] ex_lo(logic [15:0] v, bit prog, bit r16);
    if (prog && !r16) return {2'b00, v[5:0]};
    return v[7:0];
  endfunction

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // Compares all four lanes against the word v, for the current resolution pin.
  task automatic chk_word(string req, logic [15:0] v);
    chk(req, "prog hi", {8'h0, p_hi}, {8'h0, ex_hi(v, 1'b1, res16)});
    chk(req, "prog lo", {8'h0, p_lo}, {8'h0, ex_lo(v, 1'b1, res16)});
    chk(req, "fix hi",  {8'h0, f_hi}, {8'h0, ex_hi(v, 1'b0, res16)});
    chk(req, "fix lo",  {8'h0, f_lo}, {8'h0, ex_lo(v, 1'b0, res16)});
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [15:0] a, b, c, d, e;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);

    // R10: both lanes idle after reset with enables high.
    chk("R10", "idle hi drv", {15'h0, p_hd}, 16'h0);
    chk("R10", "idle lo drv", {15'h0, p_ld}, 16'h0);
    chk("R10", "idle hi data", {8'h0, p_hi}, 16'h0);
    hi_en_n = 1'b0;
    lo_en_n = 1'b0;
    wait_n(1);
    // R11: reset word is zero.
    chk_word("R11", 16'h0);

    // R7 R8 R9 R1: sweep of varied words, both resolutions, both variants.
    for (int i = 0; i < 512; i++) begin
      logic [15:0] v;
      v = 16'(i * 389 + 16'h1357) ^ 16'({i[3:0], 12'h0});
      cnt = v;
      res16 = 1'b1;
      wait_n(DLY + 1);
      chk_word("R7", v);
      chk_word("R1", v);
      res16 = 1'b0;
      wait_n(1);
      chk_word("R8", v);
      chk_word("R9", v);
    end
    res16 = 1'b1;

    // R1: exact delay, value not visible one edge early, visible on time.
    cnt = 16'h0F0F;
    wait_n(DLY + 1);
    cnt = 16'hB4D2;
    wait_n(DLY - 1);
    chk_word("R1", 16'h0F0F);
    wait_n(1);
    chk_word("R1", 16'hB4D2);

    // R10: every enable combination.
    for (int k = 0; k < 4; k++) begin
      hi_en_n = k[0];
      lo_en_n = k[1];
      wait_n(1);
      chk("R10", "hi drv", {15'h0, p_hd}, {15'h0, ~k[0]});
      chk("R10", "lo drv", {15'h0, p_ld}, {15'h0, ~k[1]});
      chk("R10", "hi data", {8'h0, p_hi}, k[0] ? 16'h0 : {8'h0, ex_hi(16'hB4D2, 1'b1, 1'b1)});
      chk("R10", "lo data", {8'h0, p_lo}, k[1] ? 16'h0 : {8'h0, ex_lo(16'hB4D2, 1'b1, 1'b1)});
      chk("R10", "fix hi data", {8'h0, f_hi}, k[0] ? 16'h0 : {8'h0, ex_hi(16'hB4D2, 1'b0, 1'b1)});
    end
    hi_en_n = 1'b0;
    lo_en_n = 1'b0;

    // R2 R6: busy launched together with new counter data keeps the old word.
    a = 16'h3A5C;
    b = 16'hC35A;
    cnt = a;
    wait_n(DLY + 2);
    busy = 1'b1;
    cnt = b;
    for (int t = 0; t < DLY + 4; t++) begin
      wait_n(1);
      chk_word("R6", a);
    end
    chk_word("R2", a);
    busy = 1'b0;
    wait_n(4);
    chk_word("R2", b);

    // R5: inhibit low freezes, release follows.
    c = 16'h7E81;
    inh_n = 1'b0;
    wait_n(3);
    cnt = c;
    wait_n(DLY + 4);
    chk_word("R5", b);
    res16 = 1'b0;
    wait_n(1);
    chk_word("R5", b);
    res16 = 1'b1;
    inh_n = 1'b1;
    wait_n(4);
    chk_word("R5", c);

    // R3: inhibit raised during busy holds the pre-busy word after busy ends.
    d = 16'h1D2E;
    busy = 1'b1;
    cnt = d;
    wait_n(3);
    inh_n = 1'b0;
    wait_n(DLY + 2);
    chk_word("R3", c);
    busy = 1'b0;
    wait_n(DLY + 3);
    chk_word("R3", c);
    inh_n = 1'b1;
    wait_n(4);
    chk_word("R3", d);

    // R4: busy during inhibit does not change the held word.
    e = 16'hE0F1;
    inh_n = 1'b0;
    wait_n(3);
    busy = 1'b1;
    cnt = e;
    wait_n(DLY + 3);
    chk_word("R4", d);
    inh_n = 1'b1;
    wait_n(DLY);
    chk_word("R4", d);
    busy = 1'b0;
    wait_n(4);
    chk_word("R4", e);

    wait_n(2);
    finish_run();
  end

endmodule